// File: doc/BRIEF.md
# Byte-Programmed Pulse-Width Modulator

This block turns a stream of received bytes into a pulse-width modulated output. Bytes arrive one at a time from an upstream serial shifter, each marked by a one-cycle valid strobe. The stream is read as pairs: a tag byte names a setting, and the byte after it supplies the value. One tag picks the period of the waveform, the other picks the high time.

The waveform comes from an 8-bit counter that runs from zero up to the period value and then wraps. The output goes high at the wrap and goes low when the counter meets the width. Each time a value is stored, the counter is stopped, both compare values are loaded together and counting starts again from zero. The new waveform therefore always begins with a clean cycle. A tag that is not recognised drops the decoder back to expecting a tag, so a stream that has lost its alignment recovers by itself.

Top module: `tagpwm_gen`

## Requirements
- R1: After a synchronous active-low reset, the period is 0xFF and the width is 0x0F. The output is high for 15 cycles out of every 256, starting in the first cycle after reset.
- R2: A tag byte of 0x51 makes the next byte the new period. A tag byte of 0x52 makes the next byte the new width.
- R3: Accepted bytes alternate between tag and value, starting with a tag after reset. A byte in a value slot is stored as data even when it equals a tag code.
- R4: A byte in a tag slot that is neither 0x51 nor 0x52 is ignored. The next byte is treated as a tag, and the waveform keeps running without a restart.
- R5: A value byte accepted at clock edge N takes effect at edge N+1. At that edge the counter restarts at zero, and the new period and the new width are both used from then on.
- R6: The counter steps from 0 up to the period value and then returns to 0, so one waveform cycle is period+1 clocks long. The output is high while the counter is below the width.
- R7: A non-zero width that is greater than or equal to the period gives an output that stays high.
- R8: A width of zero gives an output that stays low.
- R9: A byte presented while rx_valid is low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | Strobe marking rx_byte as a new received byte |
| rx_byte | input | 8 | Received byte (tag or value) |
| pwm_out | output | 1 | Registered PWM waveform |

## Verification
A misaligned tag/value toggle stores a tag code as a setting. This shows at pwm_out within one waveform cycle as a wrong high time, or as a restart that should not have happened. A wrong counter or a lost compare value shifts the next falling edge or the next wrap. A reference model of the counter and of both compare values is compared against pwm_out on every clock, so the first mismatch is caught in the cycle where it appears. On top of that, windows that each span one full period count the high cycles, which checks the duty ratio directly from the requirements.

// File: rtl/tagpwm_pkg.sv
// Shared types for the byte-programmed PWM block.
// Assumes: the consumers use the selector only inside one clock domain.
package tagpwm_pkg;

    // Which compare value the next value byte is written to
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_PER  = 2'd1,
        SEL_WID  = 2'd2
    } sel_e;

endpackage

// File: rtl/tagpwm_decoder.sv
// Tag/value decoder: reads the accepted bytes as pairs and keeps shadow
// copies of both settings. When a value is stored it raises a one-cycle
// load strobe in the next cycle.
// Assumes: rx_valid lasts one cycle per byte, and the first byte after
// reset is a tag.
module tagpwm_decoder
    import tagpwm_pkg::*;
#(
    parameter int              DW      = 8,
    parameter logic [DW-1:0]   PER_TAG = 8'h51,
    parameter logic [DW-1:0]   WID_TAG = 8'h52,
    parameter logic [DW-1:0]   RST_PER = 8'hFF,
    parameter logic [DW-1:0]   RST_WID = 8'h0F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    output logic          load_o,
    output logic [DW-1:0] per_o,
    output logic [DW-1:0] wid_o,
    output logic          value_slot_o
);

    sel_e          sel_q;
    logic          value_slot_q;
    logic [DW-1:0] per_q;
    logic [DW-1:0] wid_q;
    logic          load_q;

    // Parse the byte stream and update the selector, toggle and shadows
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q        <= SEL_NONE;
            value_slot_q <= 1'b0;
            per_q        <= RST_PER;
            wid_q        <= RST_WID;
            load_q       <= 1'b0;
        end else begin
            load_q <= 1'b0;
            if (rx_valid) begin
                if (!value_slot_q) begin
                    if (rx_byte == PER_TAG) begin
                        sel_q        <= SEL_PER;
                        value_slot_q <= 1'b1;
                    end else if (rx_byte == WID_TAG) begin
                        sel_q        <= SEL_WID;
                        value_slot_q <= 1'b1;
                    end else begin
                        sel_q        <= SEL_NONE;
                        value_slot_q <= 1'b0;
                    end
                end else begin
                    value_slot_q <= 1'b0;
                    if (sel_q == SEL_PER) begin
                        per_q  <= rx_byte;
                        load_q <= 1'b1;
                    end else if (sel_q == SEL_WID) begin
                        wid_q  <= rx_byte;
                        load_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign load_o       = load_q;
    assign per_o        = per_q;
    assign wid_o        = wid_q;
    assign value_slot_o = value_slot_q;

endmodule

// File: rtl/tagpwm_timer.sv
// Fast-PWM timer: the counter runs 0..period and wraps. A load strobe
// stops it, takes both compare values together and restarts it at 0.
// The output is registered and follows the counter and compare values
// that are in use in the same cycle.
// Assumes: per_i and wid_i are stable while load_i is high.
module tagpwm_timer #(
    parameter int            DW      = 8,
    parameter logic [DW-1:0] RST_PER = 8'hFF,
    parameter logic [DW-1:0] RST_WID = 8'h0F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] per_i,
    input  logic [DW-1:0] wid_i,
    output logic          pwm_o,
    output logic [DW-1:0] cnt_o,
    output logic [DW-1:0] per_o,
    output logic [DW-1:0] wid_o
);

    localparam logic RST_LVL = (RST_WID != '0);

    logic [DW-1:0] cnt_q, per_q, wid_q;
    logic [DW-1:0] cnt_d, per_d, wid_d;
    logic          pwm_q, lvl_d;

    // Next counter and compare values: a reload takes priority over counting
    always_comb begin
        if (load_i) begin
            cnt_d = '0;
            per_d = per_i;
            wid_d = wid_i;
        end else begin
            per_d = per_q;
            wid_d = wid_q;
            cnt_d = (cnt_q == per_q) ? '0 : cnt_q + 1'b1;
        end
    end

    // Output level for the next state: set at wrap, cleared on width match
    always_comb begin
        lvl_d = (wid_d != '0) && ((cnt_d < wid_d) || (wid_d >= per_d));
    end

    // Counter, compare values and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            per_q <= RST_PER;
            wid_q <= RST_WID;
            pwm_q <= RST_LVL;
        end else begin
            cnt_q <= cnt_d;
            per_q <= per_d;
            wid_q <= wid_d;
            pwm_q <= lvl_d;
        end
    end

    assign pwm_o = pwm_q;
    assign cnt_o = cnt_q;
    assign per_o = per_q;
    assign wid_o = wid_q;

endmodule

// File: rtl/tagpwm_gen.sv
// Top level: a byte-programmed PWM generator. The decoder turns tag/value
// byte pairs into period and width settings. The timer makes the waveform
// and restarts each time a setting changes.
// Assumes: the bytes come from an upstream shifter in this clock domain.
module tagpwm_gen #(
    parameter int            DW      = 8,
    parameter logic [DW-1:0] PER_TAG = 8'h51,
    parameter logic [DW-1:0] WID_TAG = 8'h52,
    parameter logic [DW-1:0] RST_PER = 8'hFF,
    parameter logic [DW-1:0] RST_WID = 8'h0F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    output logic          pwm_out
);

    logic          load_w;
    logic          value_slot_w;
    logic [DW-1:0] sh_per_w, sh_wid_w;
    logic [DW-1:0] cnt_w, per_w, wid_w;

    tagpwm_decoder #(
        .DW(DW), .PER_TAG(PER_TAG), .WID_TAG(WID_TAG),
        .RST_PER(RST_PER), .RST_WID(RST_WID)
    ) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_byte      (rx_byte),
        .load_o       (load_w),
        .per_o        (sh_per_w),
        .wid_o        (sh_wid_w),
        .value_slot_o (value_slot_w)
    );

    tagpwm_timer #(
        .DW(DW), .RST_PER(RST_PER), .RST_WID(RST_WID)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_w),
        .per_i  (sh_per_w),
        .wid_i  (sh_wid_w),
        .pwm_o  (pwm_out),
        .cnt_o  (cnt_w),
        .per_o  (per_w),
        .wid_o  (wid_w)
    );

endmodule

// File: rtl/tagpwm_chk.sv
// Property checker for tagpwm_gen. It is bound to every instance and
// watches the ports, the decoder strobe and the timer state.
module tagpwm_chk #(
    parameter int            DW      = 8,
    parameter logic [DW-1:0] PER_TAG = 8'h51,
    parameter logic [DW-1:0] WID_TAG = 8'h52,
    parameter logic [DW-1:0] RST_PER = 8'hFF,
    parameter logic [DW-1:0] RST_WID = 8'h0F
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic [DW-1:0] rx_byte,
    input logic          pwm_out,
    input logic          load,
    input logic          value_slot,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] per,
    input logic [DW-1:0] wid
);

    // R1
    reset_defaults_chk: assert property (@(posedge clk)
        !rst_n |=> (per == RST_PER && wid == RST_WID && cnt == '0));

    // R6
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == per) |=> cnt == '0);

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != per) |=> cnt == $past(cnt) + 1'b1);

    // R5
    reload_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == '0);

    // R4
    bad_tag_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !value_slot && rx_byte != PER_TAG && rx_byte != WID_TAG)
        |=> (!load && !value_slot));

    // R9
    idle_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !load);

    // R8
    zero_width_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wid == '0) |-> !pwm_out);

    // R7
    full_width_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wid != '0 && wid >= per) |-> pwm_out);

endmodule

bind tagpwm_gen tagpwm_chk #(
    .DW(DW), .PER_TAG(PER_TAG), .WID_TAG(WID_TAG),
    .RST_PER(RST_PER), .RST_WID(RST_WID)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .pwm_out    (pwm_out),
    .load       (load_w),
    .value_slot (value_slot_w),
    .cnt        (cnt_w),
    .per        (per_w),
    .wid        (wid_w)
);

// File: tb/tagpwm_gen_test.sv
// Bench for tagpwm_gen. A behavioural model is compared with pwm_out on
// every clock, and windows of one full period count the high cycles.
module tagpwm_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       pwm_out;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";
    bit started = 1'b0;
    bit done = 1'b0;

    // Model state
    int m_cnt, m_per, m_wid, m_sh_per, m_sh_wid, m_sel;
    bit m_value_slot;
    int q_per[$];
    int q_wid[$];

    always #5 clk = ~clk;

    tagpwm_gen uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .pwm_out(pwm_out)
    );

    function automatic bit exp_level(int c, int p, int w);
        return (w != 0) && ((c < w) || (w >= p));
    endfunction

    // Reference model: timer step first, then byte parsing (value -> pending reload)
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_cnt = 0; m_per = 255; m_wid = 15;
            m_sh_per = 255; m_sh_wid = 15; m_sel = 0; m_value_slot = 0;
            q_per.delete(); q_wid.delete();
        end else begin
            if (q_per.size() > 0) begin
                m_per = q_per.pop_front();
                m_wid = q_wid.pop_front();
                m_cnt = 0;
            end else begin
                m_cnt = (m_cnt == m_per) ? 0 : m_cnt + 1;
            end
            if (rx_valid) begin
                if (!m_value_slot) begin
                    if (rx_byte == 8'h51) begin m_sel = 1; m_value_slot = 1; end
                    else if (rx_byte == 8'h52) begin m_sel = 2; m_value_slot = 1; end
                    else begin m_sel = 0; m_value_slot = 0; end
                end else begin
                    m_value_slot = 0;
                    if (m_sel == 1) m_sh_per = rx_byte;
                    if (m_sel == 2) m_sh_wid = rx_byte;
                    if (m_sel != 0) begin
                        q_per.push_back(m_sh_per);
                        q_wid.push_back(m_sh_wid);
                    end
                end
            end
        end
    end

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (pwm_out !== exp_level(m_cnt, m_per, m_wid)) begin
                fails++;
                $display("FAIL %s pwm_out=%0b expected=%0b at %0t", cur_req,
                         pwm_out, exp_level(m_cnt, m_per, m_wid), $time);
            end
        end
    end

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Count high cycles over one window and compare with the expected duty
    task automatic duty(input string req, input int len, input int exp_hi);
        int hi = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
        checks++;
        if (hi != exp_hi) begin
            fails++;
            $display("FAIL %s high_cycles=%0d expected=%0d", req, hi, exp_hi);
        end
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state and default duty
        cur_req = "R1";
        idle(4);
        rst_n = 1'b1;
        duty("R1", 256, 15);
        duty("R1", 256, 15);

        // R2 R5 R6: period 9 keeping width 15 -> constant high (R7), then width 4
        cur_req = "R2";
        send(8'h51); send(8'h09);
        idle(3);
        duty("R7", 10, 10);
        cur_req = "R5";
        send(8'h52); send(8'h04);
        duty("R5", 10, 4);
        cur_req = "R6";
        duty("R6", 10, 4);
        duty("R6", 30, 12);

        // R4: an unknown tag is dropped; the next byte is read as a tag again
        cur_req = "R4";
        send(8'h33);
        duty("R4", 10, 4);
        send(8'h52); send(8'h06);
        duty("R4", 10, 6);

        // R3: a value byte equal to a tag code is data -> width 0x52 >= period
        cur_req = "R3";
        send(8'h52); send(8'h52);
        duty("R3", 10, 10);

        // R7: width equal to the period stays high
        cur_req = "R7";
        send(8'h52); send(8'h09);
        duty("R7", 10, 10);

        // R8: zero width stays low
        cur_req = "R8";
        send(8'h52); send(8'h00);
        duty("R8", 20, 0);

        // R9: bytes without the valid strobe do nothing
        cur_req = "R9";
        send(8'h52); send(8'h03);
        @(negedge clk); rx_byte = 8'h51;
        @(negedge clk); rx_byte = 8'h01;
        @(negedge clk); rx_byte = 8'h52;
        @(negedge clk); rx_byte = 8'h08;
        duty("R9", 10, 3);

        // R7: period 0 with a non-zero width
        cur_req = "R7";
        send(8'h51); send(8'h00);
        duty("R7", 10, 10);

        // R5: back-to-back bytes with no idle cycles
        cur_req = "R5";
        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h51;
        @(negedge clk); rx_byte = 8'h1F;
        @(negedge clk); rx_byte = 8'h52;
        @(negedge clk); rx_byte = 8'h0A;
        @(negedge clk); rx_valid = 1'b0;
        idle(1);
        duty("R5", 32, 10);
        duty("R6", 64, 20);

        // R1: reset mid-run returns to defaults
        cur_req = "R1";
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        duty("R1", 256, 15);

        finish_run();
    end

endmodule